// File: doc/BRIEF.md
# Four-Channel DMA Bus-Ownership Arbiter

This block decides, cycle by cycle, who owns the system bus: the CPU or one of four DMA channels. Each channel has a request line, a mode bit and a 16-bit unit counter. Software loads the counter before use. A channel whose counter is nonzero and whose request is high competes for the bus. A unit of transfer completes on a clock edge at which that channel holds the grant and the modelled bus raises `unit_done`.

A block-mode channel keeps the bus across consecutive units until its counter runs out. A single-mode channel hands the bus back to the CPU after every unit. The CPU then holds it for exactly one cycle before the next arbitration.

Arbitration uses fixed priority, with one exception. A request that rises around the end of a single-mode unit is treated as a late arrival, and it takes the next DMA slot ahead of older requests, even older requests of higher priority. When a counter reaches zero, a terminal-count pulse is raised and the channel drops out until it is reloaded. All pins are plain control and status lines. Nothing here carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant` is 5'b00001 (CPU) and `tc` is 0. All counters are zero, so requests are not granted until a channel is loaded.
- R2: `grant` always has exactly one bit set. Bit 0 is the CPU and bit k+1 is channel k.
- R3: When the CPU holds the bus and no late-arrival override applies, the arbiter grants the lowest-numbered channel that is requesting and has a nonzero count. The grant appears in the following cycle.
- R4: A single-mode channel (`mode[k]`=0) gives the bus back to the CPU in the cycle after each completed unit. The CPU then holds it for exactly one cycle, and a still-requesting channel is granted again after that cycle.
- R5: A block-mode channel (`mode[k]`=1) keeps the grant through consecutive units until its count is exhausted.
- R6: Each completed unit decrements the counter. When the last unit completes, `tc[k]` is high for exactly one cycle and `grant` returns to the CPU in that same cycle.
- R7: After its terminal count, a channel is not granted again, even with its request held, until its counter is reloaded with a nonzero value.
- R8: A request that rises at the edge where a single-mode unit completes, or during the CPU cycle after it, wins the next DMA slot. This holds even when an older, higher-priority request is still asserted. Among several such late arrivals, the lowest number wins.
- R9: A higher-priority channel that starts requesting during a single-mode unit is granted before the single-mode channel runs again.
- R10: While `unit_done` is low, the granted channel keeps the grant and its counter does not move.
- R11: `cfg_load[k]` loads `cfg_count` into counter k, except while channel k holds the grant, when the load is ignored. Loading zero disarms the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Per-channel DMA request, level sensitive |
| mode | input | 4 | Per-channel mode: 1 is block, 0 is single |
| cfg_load | input | 4 | Per-channel counter load strobe |
| cfg_count | input | 16 | Count value written by `cfg_load` |
| unit_done | input | 1 | Bus reports completion of the current unit |
| grant | output | 5 | One-hot bus owner: bit 0 is the CPU, bit k+1 is channel k |
| tc | output | 4 | One-cycle terminal-count pulse per channel |

## Verification
Two functions can decide the same arbitration edge: ordinary fixed priority and the late-arrival override. Both act at the edge that ends the one-cycle CPU slot after a single-mode unit.

The bench provokes the conflict by holding a higher-priority single-mode request steady and raising a lower-priority request during that CPU slot. It expects the newcomer to own the bus next and the older channel to follow one slot later. It also raises a higher-priority request during a unit and expects that channel to preempt the single-mode channel.

A second coincidence is the terminal count landing on the same edge as the release to the CPU. The bench checks that `tc` and the CPU grant appear together in that cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned CH_IDXW = $clog2(NUM_CH);
endpackage

// File: rtl/dma_unit_counter.sv
module dma_unit_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          armed,
  output logic          on_last,
  output logic          tc_pulse
);
  logic [CW-1:0] units;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      units    <= '0;
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= 1'b0;
      if (load) begin
        units <= load_val;
      end else if (dec && units != '0) begin
        units <= units - 1'b1;
        if (units == CW'(1)) tc_pulse <= 1'b1;
      end
    end
  end

  assign armed   = (units != '0);
  assign on_last = (units == CW'(1));
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  parameter int unsigned CW  = CNT_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] mode,
  input  logic [NCH-1:0] cfg_load,
  input  logic [CW-1:0]  cfg_count,
  input  logic           unit_done,
  output logic [NCH:0]   grant,
  output logic [NCH-1:0] tc
);
  localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           owner_vld;
  logic [IW-1:0]  owner_idx;
  logic [NCH-1:0] req_q, late_mask, rise;
  logic           late_win;
  logic [NCH-1:0] armed, on_last, dec, ld_ok, elig, late_cand;
  logic           late_hit, any_hit;
  logic [IW-1:0]  late_idx, any_idx;
  logic           fin, cur_last, cur_blk;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign dec[k]   = owner_vld && unit_done && (owner_idx == IW'(k));
    assign ld_ok[k] = cfg_load[k] && !(owner_vld && (owner_idx == IW'(k)));
    dma_unit_counter #(.CW(CW)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_ok[k]),
      .load_val (cfg_count),
      .dec      (dec[k]),
      .armed    (armed[k]),
      .on_last  (on_last[k]),
      .tc_pulse (tc[k])
    );
  end

  assign fin       = owner_vld && unit_done;
  assign cur_last  = on_last[owner_idx];
  assign cur_blk   = mode[owner_idx];
  assign rise      = req & ~req_q;
  assign elig      = req & armed;
  assign late_cand = late_win ? ((late_mask | rise) & elig) : '0;

  dma_prio_pick #(.N(NCH), .IW(IW)) u_pick_late (
    .vec (late_cand), .hit (late_hit), .idx (late_idx)
  );
  dma_prio_pick #(.N(NCH), .IW(IW)) u_pick_any (
    .vec (elig), .hit (any_hit), .idx (any_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_vld <= 1'b0;
      owner_idx <= '0;
      req_q     <= '0;
      late_win  <= 1'b0;
      late_mask <= '0;
    end else begin
      req_q     <= req;
      late_win  <= 1'b0;
      late_mask <= '0;
      if (owner_vld) begin
        if (fin && (cur_last || !cur_blk)) owner_vld <= 1'b0;
        if (fin && !cur_blk) begin
          late_win  <= 1'b1;
          late_mask <= rise;
        end
      end else if (any_hit) begin
        owner_vld <= 1'b1;
        owner_idx <= late_hit ? late_idx : any_idx;
      end
    end
  end

  always_comb begin
    grant = '0;
    if (owner_vld) grant[int'(owner_idx) + 1] = 1'b1;
    else           grant[0] = 1'b1;
  end
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int unsigned NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH:0]   grant,
  input logic [NCH-1:0] tc,
  input logic [NCH-1:0] mode,
  input logic           unit_done
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1); // R2

  for (genvar k = 0; k < NCH; k++) begin : g_p
    AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[k+1] && !mode[k] && unit_done) |=> grant[0]); // R4
    AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[k+1] && mode[k] && unit_done) |=> (grant[k+1] || (tc[k] && grant[0]))); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[k+1] && !unit_done) |=> (grant[k+1] && !tc[k])); // R10
    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tc[k] |=> !tc[k]); // R6
    AST_TC_WITH_CPU: assert property (@(posedge clk) disable iff (!rst_n)
      tc[k] |-> grant[0]); // R6
  end
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant     (grant),
  .tc        (tc),
  .mode      (mode),
  .unit_done (unit_done)
);

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  req = '0, mode = '0, cfg_load = '0;
  logic [15:0] cfg_count = '0;
  logic        unit_done = 1'b1;
  logic [4:0]  grant;
  logic [3:0]  tc;
  int n_chk = 0, n_bad = 0, n_hot_bad = 0;
  bit finished = 0;

  localparam logic [4:0] GC = 5'b00001;

  always #10 clk = ~clk;

  dma_req_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .cfg_load(cfg_load),
    .cfg_count(cfg_count), .unit_done(unit_done), .grant(grant), .tc(tc)
  );

  function automatic logic [4:0] gd(input int k);
    return 5'b00010 << k;
  endfunction

  always @(negedge clk) if (rst_n && $countones(grant) != 1) n_hot_bad++;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic ld(input logic [3:0] m, input logic [15:0] c);
    cfg_load = m; cfg_count = c;
    tick();
    cfg_load = '0;
  endtask

  task automatic cleanup();
    req = '0; unit_done = 1'b1;
    repeat (12) tick();
    mode = '0;
    ld(4'hF, 16'd0);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 grant after reset", 32'(grant), 32'(GC));
    chk("R1 tc after reset", 32'(tc), 0);
    req = 4'hF;
    repeat (3) tick();
    chk("R1 unloaded requests ignored", 32'(grant), 32'(GC));
    cleanup();
  endtask

  task automatic t_block();
    mode = 4'b0100; req = 4'b0100;
    ld(4'b0100, 16'd3);                                   // N1
    chk("R5 load cycle CPU", 32'(grant), 32'(GC));
    tick(); chk("R5 unit1", 32'(grant), 32'(gd(2)));
    tick(); chk("R5 unit2", 32'(grant), 32'(gd(2)));
    tick(); chk("R5 unit3", 32'(grant), 32'(gd(2)));
    tick(); chk("R6 tc pulse", 32'(tc), 32'h4);
    chk("R6 CPU with tc", 32'(grant), 32'(GC));
    tick(); chk("R6 tc one cycle", 32'(tc), 0);
    tick(); chk("R7 no regrant after tc", 32'(grant), 32'(GC));
    cleanup();
  endtask

  task automatic t_single();
    logic [4:0] exp [8];
    exp = '{GC, gd(3), GC, gd(3), GC, gd(3), GC, GC};
    mode = 4'b0000; req = 4'b1000;
    ld(4'b1000, 16'd3);
    for (int i = 0; i < 8; i++) begin
      chk($sformatf("R4 single pattern step %0d", i), 32'(grant), 32'(exp[i]));
      if (i == 6) chk("R6 single tc", 32'(tc), 32'h8);
      tick();
    end
    cleanup();
  endtask

  task automatic t_prio();
    mode = 4'b0110; req = 4'b0110;
    ld(4'b0110, 16'd1);
    tick(); chk("R3 lower index first", 32'(grant), 32'(gd(1)));
    tick(); chk("R3 slot between", 32'(grant), 32'(GC));
    tick(); chk("R3 next channel", 32'(grant), 32'(gd(2)));
    cleanup();
  endtask

  task automatic t_override();
    mode = 4'b0000;
    ld(4'b1000, 16'd2);
    req = 4'b0010;
    ld(4'b0010, 16'd3);                                   // N1
    tick(); chk("R8 old channel served", 32'(grant), 32'(gd(1)));
    tick(); chk("R8 CPU slot", 32'(grant), 32'(GC));
    req[3] = 1'b1;                                        // late arrival in slot
    tick(); chk("R8 late arrival wins", 32'(grant), 32'(gd(3)));
    tick();
    tick(); chk("R8 older follows", 32'(grant), 32'(gd(1)));
    cleanup();
  endtask

  task automatic t_hipri();
    mode = 4'b0000;
    ld(4'b0001, 16'd1);
    req = 4'b0100;
    ld(4'b0100, 16'd3);                                   // N1
    tick(); chk("R9 single served", 32'(grant), 32'(gd(2)));
    req[0] = 1'b1;
    tick();
    tick(); chk("R9 higher priority preempts", 32'(grant), 32'(gd(0)));
    tick();
    tick(); chk("R9 single resumes", 32'(grant), 32'(gd(2)));
    cleanup();
  endtask

  task automatic t_stall();
    mode = 4'b0001; req = 4'b0001; unit_done = 1'b0;
    ld(4'b0001, 16'd2);
    tick(); tick(); tick();
    chk("R10 grant held while stalled", 32'(grant), 32'(gd(0)));
    chk("R10 no tc while stalled", 32'(tc), 0);
    unit_done = 1'b1;
    tick(); chk("R10 resumed", 32'(grant), 32'(gd(0)));
    tick(); chk("R10 count intact tc", 32'(tc), 32'h1);
    cleanup();
  endtask

  task automatic t_reload();
    mode = 4'b0010; req = 4'b0010;
    ld(4'b0010, 16'd3);                                   // N1
    tick();
    ld(4'b0010, 16'd1);                                   // N3, load while owned
    tick(); chk("R11 load during ownership ignored", 32'(grant), 32'(gd(1)));
    tick(); chk("R11 full count ran", 32'(tc), 32'h2);
    tick(); tick(); chk("R7 request held no grant", 32'(grant), 32'(GC));
    ld(4'b0010, 16'd1);
    tick(); chk("R7 regrant after reload", 32'(grant), 32'(gd(1)));
    cleanup();
    req = '0;
    ld(4'b0100, 16'd2);
    ld(4'b0100, 16'd0);
    req = 4'b0100;
    repeat (3) tick();
    chk("R11 zero load disarms", 32'(grant), 32'(GC));
    cleanup();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_block();
    t_single();
    t_prio();
    t_override();
    t_hipri();
    t_stall();
    t_reload();
    chk("R2 grant one-hot throughout", 32'(n_hot_bad), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule